// File: doc/BRIEF.md
# UART receiver with error tagging

This block is the receive half of an asynchronous serial port. It watches a serial line once per pulse of an oversampling tick that runs at sixteen times the bit rate, finds the start of each character, samples every bit at its centre, checks parity and the stop bit, and stores the result as a 10-bit entry in a 16-deep FIFO. Each stored entry carries its own error flags, so software reading the FIFO can see which character was damaged. A line held low for a whole frame is reported as a framing error on a zero character, which is the standard way to detect a break.

The FIFO is drained through a valid/ready read port. `rx_valid` is high whenever at least one entry is waiting, and `rx_data` always shows the oldest entry. An entry is removed on a clock edge where `rx_valid` and `rx_ready` are both high. A high `rx_ready` with nothing waiting has no effect. The receiver has no back-pressure path to the line: if a character completes while the FIFO is full, that character is lost and a sticky overrun flag is raised. A half-full flag and an idle timeout flag let software read in bursts instead of one character at a time.

Top module: `serial_rx_tagged`

## Requirements
- R1: Each entry is 10 bits: bits 7:0 hold the data, bit 8 the parity error and bit 9 the framing error. Data arrives least significant bit first. In `rx_mode` 0 and 3 a frame is one start bit, 8 data bits and one stop bit.
- R2: In `rx_mode` 1 a frame carries 7 data bits and one parity bit. The data goes to bits 6:0, bit 7 reads 0, and bit 8 is set when the parity does not match. With `odd_parity` low the data plus parity bit must hold an even number of ones, with it high an odd number.
- R3: In `rx_mode` 2 a frame carries 8 data bits and a ninth bit that is received but not checked. In `rx_mode` 0, 2 and 3 the parity error bit reads 0.
- R4: A stop bit sampled low sets the framing error bit. A line held low for many bit periods gives exactly one entry, 0x200. The receiver then waits for the line to go high before it looks for a new start bit.
- R5: The start bit is confirmed on the 8th tick after the falling edge. A low pulse shorter than that stores nothing.
- R6: `rx_valid` is high whenever at least one entry is stored. Entries leave in arrival order. A read strobe while `rx_valid` is low has no effect.
- R7: `half_full` is high when the FIFO holds 8 or more entries.
- R8: A character that completes while the FIFO is full and is not being read is dropped, and `overrun` goes high and stays high. The next read clears it. The 16 stored entries are kept.
- R9: A pulse on `flush` empties the FIFO and clears `overrun`.
- R10: With `idle_limit` not zero, `timeout` rises once the receiver has been idle with data waiting for `idle_limit` bit periods of 16 ticks. Each stored character and each read restarts the count. An empty FIFO or an `idle_limit` of 0 keeps `timeout` low.
- R11: While `rx_en` is low, no characters are received or stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input line, idles high |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_en | input | 1 | Receive enable |
| rx_mode | input | 2 | Frame format: 0 and 3 = 8 data bits, 1 = 7 data bits + parity, 2 = 8 data bits + unchecked ninth bit |
| odd_parity | input | 1 | Selects odd parity in mode 1 |
| idle_limit | input | 8 | Idle timeout in bit periods; 0 disables it |
| rx_ready | input | 1 | Read strobe (ready side of the read port) |
| flush | input | 1 | Empties the FIFO |
| rx_valid | output | 1 | At least one entry is waiting |
| rx_data | output | 10 | Oldest entry: {framing error, parity error, data} |
| half_full | output | 1 | FIFO holds at least 8 entries |
| overrun | output | 1 | Sticky: a character was lost because the FIFO was full |
| timeout | output | 1 | The line has been idle too long with data waiting |

## Verification
A bit counter or sample phase that is off by one shows up in the very next entry: the data is shifted, or the parity or stop bit is wrong, as soon as that frame's stop bit is sampled. A wrong FIFO pointer shows as reordered or repeated data on `rx_data` within the following reads. A fill count that drifts moves `half_full` or the overrun edge by one character, and the tests hit those edges exactly. Faults in the idle timer show one bit period early or late, or they show as a flag that does not drop in the cycle after a read.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DATA_W  = 8;
  localparam int ENTRY_W = DATA_W + 2;
  localparam int PE_BIT  = DATA_W;
  localparam int FE_BIT  = DATA_W + 1;

  localparam logic [1:0] FMT_8N  = 2'd0;
  localparam logic [1:0] FMT_7P  = 2'd1;
  localparam logic [1:0] FMT_8X  = 2'd2;
  localparam logic [1:0] FMT_8N2 = 2'd3;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_BITS, RX_STOP, RX_HOLD
  } rx_state_e;
endpackage

// File: rtl/srx_deframer.sv
module srx_deframer import srx_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_s,
  input  logic               tick,
  input  logic               en,
  input  logic [1:0]         fmt,
  input  logic               odd_par,
  output logic               push,
  output logic [ENTRY_W-1:0] entry,
  output logic               busy
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] MID_M1  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OVS - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [3:0]        idx;
  logic [3:0]        last_idx;
  logic [DATA_W-1:0] sh;
  logic              pe_calc;
  logic [DATA_W-1:0] data_out;

  always_comb begin
    case (fmt)
      FMT_7P:  last_idx = 4'd7;
      FMT_8X:  last_idx = 4'd8;
      default: last_idx = 4'd7;
    endcase
  end

  // Parity is checked only in the 7-bit format; the 8-bit formats report 0.
  always_comb begin
    if (fmt == FMT_7P) begin
      pe_calc  = (^sh) ^ odd_par;
      data_out = {1'b0, sh[6:0]};
    end else begin
      pe_calc  = 1'b0;
      data_out = sh;
    end
  end

  assign busy = (state != RX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      cnt   <= '0;
      idx   <= '0;
      sh    <= '0;
      push  <= 1'b0;
      entry <= '0;
    end else begin
      push <= 1'b0;
      if (!en) begin
        state <= RX_IDLE;
        cnt   <= '0;
      end else if (tick) begin
        case (state)
          RX_IDLE: begin
            if (!line_s) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (cnt == MID_M1) begin
              cnt <= '0;
              idx <= '0;
              state <= line_s ? RX_IDLE : RX_BITS;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_BITS: begin
            if (cnt == FULL_M1) begin
              cnt <= '0;
              if (idx < 4'd8) sh[idx[2:0]] <= line_s;
              if (idx == last_idx) state <= RX_STOP;
              else idx <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == FULL_M1) begin
              cnt   <= '0;
              push  <= 1'b1;
              entry <= {~line_s, pe_calc, data_out};
              state <= line_s ? RX_IDLE : RX_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_HOLD: begin
            if (line_s) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH):0]       count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_pop, do_push;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_pop  = pop && !empty && !flush;
  assign do_push = push && (!full || do_pop) && !flush;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop) count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/srx_idle_timer.sv
module srx_idle_timer #(
  parameter int OVS = 16,
  parameter int TW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  localparam int PW = $clog2(OVS);

  logic [PW-1:0] pre;
  logic [TW-1:0] periods;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= '0;
      periods <= '0;
    end else if (restart) begin
      pre     <= '0;
      periods <= '0;
    end else if (tick) begin
      if (pre == PW'(OVS-1)) begin
        pre <= '0;
        if (periods != '1) periods <= periods + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assign expired = (limit != '0) && (periods >= limit);
endmodule

// File: rtl/serial_rx_tagged.sv
module serial_rx_tagged import srx_pkg::*; #(
  parameter int OVS   = 16,
  parameter int DEPTH = 16,
  parameter int TMO_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_line,
  input  logic               tick16,
  input  logic               rx_en,
  input  logic [1:0]         rx_mode,
  input  logic               odd_parity,
  input  logic [TMO_W-1:0]   idle_limit,
  input  logic               rx_ready,
  input  logic               flush,
  output logic               rx_valid,
  output logic [ENTRY_W-1:0] rx_data,
  output logic               half_full,
  output logic               overrun,
  output logic               timeout
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [1:0]         sync_q;
  logic               fr_push;
  logic [ENTRY_W-1:0] fr_entry;
  logic               fr_busy;
  logic               f_empty, f_full;
  logic [CW-1:0]      f_count;
  logic               pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_line};
  end

  srx_deframer #(.OVS(OVS)) u_deframer (
    .clk(clk), .rst_n(rst_n), .line_s(sync_q[1]), .tick(tick16), .en(rx_en),
    .fmt(rx_mode), .odd_par(odd_parity),
    .push(fr_push), .entry(fr_entry), .busy(fr_busy)
  );

  assign pop = rx_ready && !f_empty;

  srx_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(fr_push), .wdata(fr_entry),
    .pop(pop), .rdata(rx_data), .empty(f_empty), .full(f_full), .count(f_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             overrun <= 1'b0;
    else if (flush || pop)                  overrun <= 1'b0;
    else if (fr_push && f_full)             overrun <= 1'b1;
  end

  srx_idle_timer #(.OVS(OVS), .TW(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick16),
    .restart(fr_push || pop || flush || f_empty || fr_busy),
    .limit(idle_limit), .expired(timeout)
  );

  assign rx_valid  = !f_empty;
  assign half_full = (f_count >= CW'(DEPTH/2));
endmodule

// File: rtl/srx_checks.sv
module srx_checks (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic rx_valid,
  input logic rx_ready,
  input logic flush,
  input logic overrun,
  input logic timeout,
  input logic fr_push
);
  // R9: a flush leaves the FIFO empty on the next cycle
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rx_valid);

  // R8: a read clears the sticky overrun flag
  p_read_clears_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !overrun);

  // R6: a completed character is visible at the read port one cycle later
  p_push_gives_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_push && !flush) |=> rx_valid);

  // R10: a read restarts the idle count, so the flag drops
  p_read_clears_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !timeout);

  // R11: nothing completes while receive is disabled
  p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !fr_push);
endmodule

bind serial_rx_tagged srx_checks u_checks (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .flush(flush), .overrun(overrun), .timeout(timeout),
  .fr_push(fr_push)
);

// File: tb/serial_rx_tagged_tb.sv
`timescale 1ns/1ps
module serial_rx_tagged_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       tick16 = 1'b0;
  logic       rx_en = 1'b1;
  logic [1:0] rx_mode = 2'd0;
  logic       odd_parity = 1'b0;
  logic [7:0] idle_limit = 8'd0;
  logic       rx_ready = 1'b0;
  logic       flush = 1'b0;
  logic       rx_valid;
  logic [9:0] rx_data;
  logic       half_full, overrun, timeout;

  int checks = 0;
  int fails  = 0;
  int tdiv   = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tdiv   = (tdiv == 3) ? 0 : tdiv + 1;
    tick16 = (tdiv == 0);
  end

  serial_rx_tagged u_dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16), .rx_en(rx_en),
    .rx_mode(rx_mode), .odd_parity(odd_parity), .idle_limit(idle_limit),
    .rx_ready(rx_ready), .flush(flush), .rx_valid(rx_valid), .rx_data(rx_data),
    .half_full(half_full), .overrun(overrun), .timeout(timeout)
  );

  // {mode[23:22], odd[21], line bits[20:12], stop[11], spare[10], expected entry[9:0]}
  localparam logic [23:0] VEC [10] = '{
    {2'd0, 1'b0, 9'h0A5, 1'b1, 1'b0, 10'h0A5},   // R1 plain 8-bit
    {2'd0, 1'b0, 9'h03C, 1'b0, 1'b0, 10'h23C},   // R4 bad stop
    {2'd1, 1'b0, 9'h041, 1'b1, 1'b0, 10'h041},   // R2 even ok
    {2'd1, 1'b0, 9'h0C1, 1'b1, 1'b0, 10'h141},   // R2 even bad
    {2'd1, 1'b1, 9'h0C1, 1'b1, 1'b0, 10'h041},   // R2 odd ok
    {2'd1, 1'b1, 9'h041, 1'b1, 1'b0, 10'h141},   // R2 odd bad
    {2'd2, 1'b0, 9'h1FF, 1'b1, 1'b0, 10'h0FF},   // R3 ninth bit ignored
    {2'd2, 1'b0, 9'h000, 1'b1, 1'b0, 10'h000},   // R3
    {2'd3, 1'b0, 9'h05A, 1'b1, 1'b0, 10'h05A},   // R1 mode 3
    {2'd0, 1'b1, 9'h081, 1'b1, 1'b0, 10'h081}    // R3 odd ignored in 8-bit
  };

  task automatic wait_clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nbits(logic [1:0] m);
    return (m == 2'd2) ? 9 : 8;
  endfunction

  // one bit period = 16 ticks = 64 clocks
  task automatic send_frame(logic [1:0] m, logic [8:0] bits, logic stop);
    rx_line = 1'b0;
    wait_clks(64);
    for (int i = 0; i < nbits(m); i++) begin
      rx_line = bits[i];
      wait_clks(64);
    end
    rx_line = stop;
    wait_clks(64);
    rx_line = 1'b1;
    wait_clks(128);
  endtask

  task automatic pop_one();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_clks(5);
    // R6 reset state
    chk("R6 reset valid", rx_valid, 0);
    chk("R7 reset half", half_full, 0);
    chk("R8 reset overrun", overrun, 0);
    chk("R10 reset timeout", timeout, 0);
    rst_n = 1'b1;
    wait_clks(8);
    pop_one();
    chk("R6 read while empty ignored", rx_valid, 0);

    for (int v = 0; v < 10; v++) begin
      rx_mode    = VEC[v][23:22];
      odd_parity = VEC[v][21];
      send_frame(VEC[v][23:22], VEC[v][20:12], VEC[v][11]);
      chk($sformatf("R1 vector %0d valid", v), rx_valid, 1);
      chk($sformatf("R1 R2 R3 vector %0d entry", v), rx_data, VEC[v][9:0]);
      pop_one();
    end
    rx_mode = 2'd0;
    odd_parity = 1'b0;
    chk("R6 drained after table", rx_valid, 0);

    // R5 short glitch
    rx_line = 1'b0;
    wait_clks(20);
    rx_line = 1'b1;
    wait_clks(64 * 12);
    chk("R5 glitch stores nothing", rx_valid, 0);

    // R4 long break gives one entry
    rx_line = 1'b0;
    wait_clks(64 * 15);
    rx_line = 1'b1;
    wait_clks(64 * 4);
    chk("R4 break valid", rx_valid, 1);
    chk("R4 break entry", rx_data, 10'h200);
    pop_one();
    chk("R4 single break entry", rx_valid, 0);

    // R11 receive disabled
    rx_en = 1'b0;
    send_frame(2'd0, 9'h055, 1'b1);
    chk("R11 disabled stores nothing", rx_valid, 0);
    rx_en = 1'b1;
    wait_clks(8);

    // R7 / R8 fill, half mark, overrun
    for (int i = 0; i < 16; i++) begin
      send_frame(2'd0, 9'(8'h10 + i), 1'b1);
      if (i == 6) chk("R7 half at 7", half_full, 0);
      if (i == 7) chk("R7 half at 8", half_full, 1);
    end
    chk("R8 no overrun when just full", overrun, 0);
    send_frame(2'd0, 9'h0EE, 1'b1);
    chk("R8 overrun set", overrun, 1);
    chk("R8 head kept", rx_data, 10'h010);
    for (int i = 0; i < 16; i++) begin
      chk("R6 R8 order", rx_data, 10'(8'h10 + i));
      pop_one();
      if (i == 0) chk("R8 read clears overrun", overrun, 0);
    end
    chk("R8 extra char dropped", rx_valid, 0);

    // R9 flush
    send_frame(2'd0, 9'h011, 1'b1);
    send_frame(2'd0, 9'h022, 1'b1);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk("R9 flush empties", rx_valid, 0);
    send_frame(2'd0, 9'h033, 1'b1);
    chk("R9 usable after flush", rx_data, 10'h033);
    pop_one();

    // R10 timeout, limit 3 bit periods
    idle_limit = 8'd3;
    send_frame(2'd0, 9'h044, 1'b1);
    chk("R10 not yet expired", timeout, 0);
    wait_clks(64);
    chk("R10 expired", timeout, 1);
    pop_one();
    chk("R10 cleared by read", timeout, 0);

    send_frame(2'd0, 9'h061, 1'b1);
    send_frame(2'd0, 9'h062, 1'b1);
    wait_clks(64);
    chk("R10 expired with two", timeout, 1);
    pop_one();
    chk("R10 restart on read", timeout, 0);
    chk("R6 one left", rx_data, 10'h062);
    wait_clks(160);
    chk("R10 restart early", timeout, 0);
    wait_clks(64);
    chk("R10 expired again", timeout, 1);
    pop_one();
    chk("R10 empty clears", timeout, 0);

    idle_limit = 8'd0;
    send_frame(2'd0, 9'h077, 1'b1);
    wait_clks(1600);
    chk("R10 zero limit disables", timeout, 0);
    pop_one();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule